// File: doc/BRIEF.md
# Dual-Rail Handshaking Stage Register

This block is one storage stage of a clockless dual-rail pipeline, written as a cycle-based emulation: each hysteresis threshold gate of the stage is a state element that is updated once per clock, so one clock stands for one gate delay. Every data bit travels as a group of two rails, one for a logic 0 and one for a logic 1. With both rails low the group is NULL, the spacer that separates one data wavefront from the next.

Each stored rail is a 2-of-2 hysteresis gate fed by the incoming rail and by the request from the next stage. A DATA wavefront is therefore captured only while DATA is requested, and a NULL wavefront only while NULL is requested. A completion detector watches the stage outputs. One-of-two gates reduce each group to a single flag, and a tree of all-of-n hysteresis gates merges the flags. The inverted detector output is the request sent to the previous stage. Stages are chained by linking each stage's data outputs to the next stage's data inputs, and each stage's request output to the previous stage's request input.

Top module: `ncl_stage_reg`

## Requirements
- R1: While reset is asserted, every output rail is low (all groups NULL) and `req_out` is 1, so the stage asks for DATA.
- R2: An output rail can go high only while `req_in` is 1 (DATA requested). While `req_in` is 1, stored DATA is held even after the input returns to NULL. DATA offered while `req_in` is 0 leaves the outputs unchanged.
- R3: An output rail can go low only while `req_in` is 0 (NULL requested) and its input rail is low. Stored DATA is held while `req_in` is 0 and the input still carries DATA.
- R4: `req_out` goes to 0 (ask for NULL) once every output group holds DATA. While any output group is still NULL, `req_out` stays 1.
- R5: After `req_out` has gone to 0, it returns to 1 only when every output group is NULL. While any group still holds DATA, it stays 0.
- R6: Group g occupies bits 2g+1 (the rail meaning logic 1) and 2g (the rail meaning logic 0) of `din` and `dout`. With valid inputs, no output group ever has both rails high.
- R7: In a chain of three stages fed by a four-phase producer and consumer, every value reaches the end exactly once, in order, with no two DATA wavefronts merged, and two DATA wavefronts are held in different stages at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock; one edge is one gate delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 2*GROUPS | Dual-rail groups from the previous stage |
| req_in | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for NULL |
| dout | output | 2*GROUPS | Stored dual-rail groups toward the next stage |
| req_out | output | 1 | Request to the previous stage: 1 asks for DATA, 0 asks for NULL |

## Verification
A new wavefront can arrive at `din` in the same cycle that `req_in` turns against it: DATA can arrive while NULL is requested, or NULL while DATA is requested. Capture and hold then collide. The bench provokes this directly on a single stage by presenting DATA with the request low, and later dropping the input to NULL with the request high. It judges the stage by the stored outputs and by `req_out` a few gate delays later. In the three-stage chain, the consumer's variable stall makes downstream requests change while upstream wavefronts are still arriving, and the scoreboard checks order and integrity at the last stage.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

  // Bit position of each rail inside a two-bit group.
  localparam int RAIL_ZERO = 0;
  localparam int RAIL_ONE  = 1;

  // Number of gate levels in the completion tree (at least one).
  function automatic int tree_levels(input int n, input int f);
    int w;
    int l;
    w = n;
    l = 0;
    do begin
      w = (w + f - 1) / f;
      l++;
    end while (w > 1);
    return l;
  endfunction

  // Number of nodes on a given level; level 0 is the per-group flags.
  function automatic int level_width(input int n, input int f, input int lvl);
    int w;
    w = n;
    for (int i = 0; i < lvl; i++) w = (w + f - 1) / f;
    return w;
  endfunction

  // Start of a level inside the flattened node vector.
  function automatic int level_offset(input int n, input int f, input int lvl);
    int o;
    o = 0;
    for (int i = 0; i < lvl; i++) o += level_width(n, f, i);
    return o;
  endfunction

endpackage

// File: rtl/ncl_thnn.sv
// All-of-n hysteresis threshold gate: sets when every input is high,
// clears when every input is low, holds otherwise. One clock = one gate delay.
module ncl_thnn #(
  parameter int INPUTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INPUTS-1:0] th_in,
  output logic              th_q
);

  logic state_q;
  logic state_d;
  logic upd_en;

  always_comb begin
    upd_en  = (&th_in) | (~|th_in);
    state_d = &th_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end

  assign th_q = state_q;

  // Gate output rises only after all inputs were high (capture rule, R2)
  assert_gate_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_q) |-> $past(&th_in));

  // Gate output falls only after all inputs were low (clear rule, R3)
  assert_gate_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(th_q) |-> $past(~|th_in));

endmodule

// File: rtl/ncl_rail_bank.sv
// One 2-of-2 hysteresis gate per rail, joined with the downstream request.
module ncl_rail_bank #(
  parameter int GROUPS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*GROUPS-1:0] rail_in,
  input  logic                req_in,
  output logic [2*GROUPS-1:0] rail_q
);

  localparam int RAILS = 2 * GROUPS;

  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    ncl_thnn #(.INPUTS(2)) u_th22 (
      .clk   (clk),
      .rst_n (rst_n),
      .th_in ({rail_in[i], req_in}),
      .th_q  (rail_q[i])
    );
  end

endmodule

// File: rtl/ncl_completion.sv
// Completion detector: one-of-two per group, then a tree of all-of-n
// hysteresis gates. FANIN must be 2 or more.
module ncl_completion #(
  parameter int GROUPS = 8,
  parameter int FANIN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*GROUPS-1:0] rails,
  output logic                all_data
);
  import ncl_pkg::*;

  localparam int LEVELS = tree_levels(GROUPS, FANIN);
  localparam int NODES  = level_offset(GROUPS, FANIN, LEVELS + 1);

  logic [NODES-1:0] node;

  // Level 0: one-of-two per group (no state needed for a single set rail).
  for (genvar g = 0; g < GROUPS; g++) begin : g_flag
    assign node[g] = rails[2*g+RAIL_ONE] | rails[2*g+RAIL_ZERO];
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int PW = level_width(GROUPS, FANIN, l - 1);
    localparam int W  = level_width(GROUPS, FANIN, l);
    localparam int PO = level_offset(GROUPS, FANIN, l - 1);
    localparam int O  = level_offset(GROUPS, FANIN, l);
    for (genvar j = 0; j < W; j++) begin : g_gate
      localparam int LO  = j * FANIN;
      localparam int CNT = ((PW - LO) < FANIN) ? (PW - LO) : FANIN;
      ncl_thnn #(.INPUTS(CNT)) u_thn (
        .clk   (clk),
        .rst_n (rst_n),
        .th_in (node[PO+LO +: CNT]),
        .th_q  (node[O+j])
      );
    end
  end

  assign all_data = node[NODES-1];

endmodule

// File: rtl/ncl_stage_reg.sv
module ncl_stage_reg #(
  parameter int GROUPS = 8,
  parameter int FANIN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*GROUPS-1:0] din,
  input  logic                req_in,
  output logic [2*GROUPS-1:0] dout,
  output logic                req_out
);
  import ncl_pkg::*;

  logic [2*GROUPS-1:0] stored;
  logic                complete;

  ncl_rail_bank #(.GROUPS(GROUPS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rail_in (din),
    .req_in  (req_in),
    .rail_q  (stored)
  );

  ncl_completion #(.GROUPS(GROUPS), .FANIN(FANIN)) u_done (
    .clk      (clk),
    .rst_n    (rst_n),
    .rails    (stored),
    .all_data (complete)
  );

  assign dout    = stored;
  assign req_out = ~complete;

  // No rail falls in a cycle where DATA was requested (R2 hold)
  assert_hold_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_in) |-> ((~dout & $past(dout)) == '0));

  // No rail rises in a cycle where NULL was requested (R3)
  assert_hold_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_in) |-> ((dout & ~$past(dout)) == '0));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    // With valid inputs, a group never shows both rails (R6)
    assert_one_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (din[2*g+RAIL_ONE] & din[2*g+RAIL_ZERO]) == 1'b0 |=>
      (dout[2*g+RAIL_ONE] & dout[2*g+RAIL_ZERO]) == 1'b0);
  end

endmodule

// File: tb/ncl_stage_reg_bench.sv
`timescale 1ns/1ps
module ncl_stage_reg_bench;

  localparam int G   = 8;
  localparam int W   = 2 * G;
  localparam int NUM = 40;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  // Single stage under directed test
  logic [W-1:0] d_din;
  logic         d_req;
  logic [W-1:0] d_dout;
  logic         d_rout;

  ncl_stage_reg u_ncl_stage_reg (
    .clk(clk), .rst_n(rst_n), .din(d_din), .req_in(d_req),
    .dout(d_dout), .req_out(d_rout));

  // Three-stage chain
  logic [W-1:0] c_d0, c_d1, c_d2, c_d3;
  logic         c_r0, c_r1, c_r2, c_cons;

  ncl_stage_reg u_chain0 (.clk(clk), .rst_n(rst_n), .din(c_d0), .req_in(c_r1),
    .dout(c_d1), .req_out(c_r0));
  ncl_stage_reg u_chain1 (.clk(clk), .rst_n(rst_n), .din(c_d1), .req_in(c_r2),
    .dout(c_d2), .req_out(c_r1));
  ncl_stage_reg u_chain2 (.clk(clk), .rst_n(rst_n), .din(c_d2), .req_in(c_cons),
    .dout(c_d3), .req_out(c_r2));

  // Encoding from R6: bit 2g+1 is the logic-1 rail, bit 2g the logic-0 rail.
  function automatic logic [W-1:0] enc(input logic [G-1:0] v);
    logic [W-1:0] r;
    for (int g = 0; g < G; g++) begin
      r[2*g+1] = v[g];
      r[2*g]   = ~v[g];
    end
    return r;
  endfunction

  function automatic bit full(input logic [W-1:0] x);
    bit f;
    f = 1'b1;
    for (int g = 0; g < G; g++) if (!(x[2*g] | x[2*g+1])) f = 1'b0;
    return f;
  endfunction

  function automatic bit bad_group(input logic [W-1:0] x);
    bit b;
    b = 1'b0;
    for (int g = 0; g < G; g++) if (x[2*g] & x[2*g+1]) b = 1'b1;
    return b;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  logic [G-1:0] expq[$];
  int occ_max = 0;

  // Count stages holding a complete DATA wavefront at the same time (R7)
  always @(negedge clk) begin
    int occ;
    occ = int'(full(c_d1)) + int'(full(c_d2)) + int'(full(c_d3));
    if (rst_n && occ > occ_max) occ_max = occ;
  end

  task automatic producer();
    for (int i = 0; i < NUM; i++) begin
      logic [G-1:0] v;
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : G'(i * 37 + 11);
      while (c_r0 !== 1'b1) @(negedge clk);
      c_d0 = enc(v);
      expq.push_back(v);
      while (c_r0 !== 1'b0) @(negedge clk);
      c_d0 = '0;
    end
  endtask

  task automatic consumer();
    for (int i = 0; i < NUM; i++) begin
      logic [G-1:0] e;
      while (!full(c_d3)) begin
        if (bad_group(c_d3)) chk("R6 chain output group", c_d3, '0);
        @(negedge clk);
      end
      e = expq.pop_front();
      chk("R7 chain order and integrity", c_d3, enc(e));
      repeat ((i % 4) * 3) @(negedge clk);
      c_cons = 1'b0;
      while (c_d3 !== '0) @(negedge clk);
      c_cons = 1'b1;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] part;
    rst_n  = 1'b1;
    d_din  = '0;
    d_req  = 1'b1;
    c_d0   = '0;
    c_cons = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset dout", d_dout, '0);
    chk("R1 reset req_out", W'(d_rout), W'(1));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Partial DATA: group 7 still NULL
    part  = enc(8'hA5) & ~(W'(3) << 14);
    d_din = part;
    settle();
    chk("R2 capture partial", d_dout, part);
    chk("R4 partial keeps req_out", W'(d_rout), W'(1));

    d_din = enc(8'hA5);
    settle();
    chk("R2 capture full", d_dout, enc(8'hA5));
    chk("R4 complete drops req_out", W'(d_rout), W'(0));

    // NULL arrives while DATA still requested: hold
    d_din = '0;
    settle();
    chk("R2 hold under DATA request", d_dout, enc(8'hA5));

    // NULL requested but input still DATA: hold
    d_din = enc(8'hA5);
    d_req = 1'b0;
    settle();
    chk("R3 hold while input DATA", d_dout, enc(8'hA5));

    // Only group 0 returns to NULL
    d_din = enc(8'hA5) & ~W'(3);
    settle();
    chk("R3 group 0 cleared", d_dout, enc(8'hA5) & ~W'(3));
    chk("R5 partial NULL keeps req_out", W'(d_rout), W'(0));

    d_din = '0;
    settle();
    chk("R5 all NULL", d_dout, '0);
    chk("R5 req_out back to DATA", W'(d_rout), W'(1));

    // DATA offered while NULL requested: ignored
    d_din = enc(8'h3C);
    settle();
    chk("R2 DATA ignored under NULL request", d_dout, '0);
    chk("R2 req_out unchanged", W'(d_rout), W'(1));

    d_req = 1'b1;
    settle();
    chk("R2 capture after request", d_dout, enc(8'h3C));
    chk("R4 req_out after capture", W'(d_rout), W'(0));

    fork
      producer();
      consumer();
    join
    settle();
    chk("R7 all values drained", W'(expq.size()), W'(0));
    chk("R7 two wavefronts in flight", W'(occ_max >= 2), W'(1));
    summary();
  end

endmodule